// File: doc/BRIEF.md
# Lattice KEM Noise-Sampling Sequencer

This controller schedules the noise polynomials that a centered-binomial sampler draws for a module-lattice key-encapsulation engine. After a start pulse it walks through every polynomial that the selected operation needs. For each one it picks the seed, the nonce, the binomial width eta and the destination in polynomial storage. It then hands one request to the sampler and waits for that polynomial to finish before it moves on. The hash/PRF, the binomial arithmetic and the polynomial memories all sit outside the block.

There are two modes. Key generation draws 2K polynomials from the sigma seed, all with eta1. Encapsulation draws 2K+1 polynomials from the r seed. The first K of these (y) use eta1. The next K (e1) and the last one (e2) use eta2. The y and e1 polynomials go to the secret/error bank. The final e2 goes to the t bank instead. Slots are given as absolute indices into a 28-slot space: the secret/error bank starts after the K*K matrix slots, and the t bank starts after that bank's 2K slots.

Top module: `noise_seq_ctrl`

## Requirements
- R1: An active-low asynchronous reset returns the block to idle with busy_o, done_o and req_valid_o low, and clears the polynomial counter, so the next run starts at nonce 0.
- R2: A start pulse is accepted only while idle and only when K is 2, 3 or 4. A start pulse while busy, or with any other K, has no effect on the outputs or on the running sequence.
- R3: In key-generation mode (mode_i=0) the block issues exactly 2K requests. Each carries seed sigma_i, nonce 0..2K-1 in order, eta1, bank 0 (req_bank_o=0) and absolute slot K*K+i for request i.
- R4: In encapsulation mode (mode_i=1) the block issues exactly 2K+1 requests with seed r_i and nonce 0..2K, increasing by one per request.
- R5: eta1 is 3 when K=2 and 2 when K=3 or 4. eta2 is always 2. In encapsulation, requests 0..K-1 use eta1 and requests K..2K use eta2.
- R6: In encapsulation, request i<K (y[i]) targets bank 0 slot K*K+i. Request K+i (e1[i]) targets bank 0 slot K*K+K+i. Request 2K (e2) targets bank 1 (t bank) at slot K*K+2K. Every slot is below 28.
- R7: req_valid_o rises in the cycle after start is accepted, and in the cycle after samp_done_i is sampled for a request that is not the last. It stays high with all request fields stable until req_ready_i is sampled high. It then stays low until the next request.
- R8: done_o is high for exactly one cycle, the cycle after samp_done_i is sampled for the final request. busy_o stays high through that cycle and is low in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| mode_i | input | 1 | 0 = key generation, 1 = encapsulation |
| k_i | input | 3 | Module rank K (2, 3 or 4) |
| sigma_i | input | 256 | Key-generation noise seed |
| r_i | input | 256 | Encapsulation noise seed |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| req_valid_o | output | 1 | Sampler request pending |
| req_ready_i | input | 1 | Sampler accepts the request |
| req_seed_o | output | 256 | Seed for the PRF |
| req_nonce_o | output | 8 | PRF nonce |
| req_eta_o | output | 2 | Binomial width eta |
| req_bank_o | output | 1 | 0 = secret/error bank, 1 = t bank |
| req_slot_o | output | 5 | Absolute destination slot |
| samp_done_i | input | 1 | Sampler finished the accepted polynomial |

## Verification
The assertions assume the sampler never signals samp_done_i before it has accepted a request, and never raises req_ready_i when no request is valid. The bench responder keeps to this. It raises ready only after it has seen req_valid_o at a falling edge, and it pulses samp_done_i only after the ack cycle has passed. The seeds and K are held steady around each start. Deliberate start pulses during a run, and starts with an illegal K, are the only stimulus outside the normal handshake.

// File: rtl/noise_seq_pkg.sv
package noise_seq_pkg;
  localparam int SEED_W     = 256;
  localparam int NONCE_W    = 8;
  localparam int SLOT_W     = 5;
  localparam int SLOT_COUNT = 28;
  localparam int K_W        = 3;
  localparam int K_MIN      = 2;
  localparam int K_MAX      = 4;
  localparam int ETA_W      = 2;
  localparam int ETA1_K2    = 3;
  localparam int ETA_STD    = 2;
  localparam int NUM_BANKS  = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} seq_state_e;
  typedef enum logic {BANK_SE = 1'b0, BANK_T = 1'b1} bank_e;
  typedef enum logic {MODE_KEYGEN = 1'b0, MODE_ENCAPS = 1'b1} mode_e;
endpackage

// File: rtl/noise_seq_plan.sv
// Per-polynomial decode: eta, bank, relative slot, last flag.
module noise_seq_plan
  import noise_seq_pkg::*;
#(
  parameter int KW    = K_W,
  parameter int IW    = K_W + 1,
  parameter int SW    = SLOT_W,
  parameter int EW    = ETA_W
) (
  input  logic          mode_i,
  input  logic [KW-1:0] k_i,
  input  logic [IW-1:0] idx_i,
  output logic [EW-1:0] eta_o,
  output logic          bank_o,
  output logic [SW-1:0] rel_o,
  output logic          last_o
);
  logic [IW-1:0] k_ext, two_k, total;
  logic [EW-1:0] eta1;
  logic          is_e2;

  always_comb begin
    k_ext  = IW'(k_i);
    two_k  = k_ext << 1;
    total  = two_k + IW'(mode_i);
    last_o = (idx_i == total - IW'(1));
    eta1   = (k_i == KW'(2)) ? EW'(ETA1_K2) : EW'(ETA_STD);
    is_e2  = (mode_i == MODE_ENCAPS) && (idx_i == two_k);
    eta_o  = ((mode_i == MODE_ENCAPS) && (idx_i >= k_ext)) ? EW'(ETA_STD) : eta1;
    bank_o = is_e2 ? BANK_T : BANK_SE;
    rel_o  = is_e2 ? '0 : SW'(idx_i);
  end
endmodule

// File: rtl/noise_seq_slot_map.sv
// Relative -> absolute slot; bank b base = K*K + b*2K.
module noise_seq_slot_map
  import noise_seq_pkg::*;
#(
  parameter int KW    = K_W,
  parameter int SW    = SLOT_W,
  parameter int NB    = NUM_BANKS,
  localparam int BW   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [KW-1:0] k_i,
  input  logic [BW-1:0] bank_i,
  input  logic [SW-1:0] rel_i,
  output logic [SW-1:0] abs_o
);
  logic [SW-1:0] k_sq, two_k;
  logic [SW-1:0] base [NB];

  assign k_sq  = SW'(k_i) * SW'(k_i);
  assign two_k = SW'(k_i) << 1;

  for (genvar b = 0; b < NB; b++) begin : g_base
    assign base[b] = k_sq + SW'(b) * two_k;
  end

  assign abs_o = base[bank_i] + rel_i;
endmodule

// File: rtl/noise_seq_ctrl.sv
module noise_seq_ctrl
  import noise_seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                mode_i,
  input  logic [K_W-1:0]      k_i,
  input  logic [SEED_W-1:0]   sigma_i,
  input  logic [SEED_W-1:0]   r_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic [SEED_W-1:0]   req_seed_o,
  output logic [NONCE_W-1:0]  req_nonce_o,
  output logic [ETA_W-1:0]    req_eta_o,
  output logic                req_bank_o,
  output logic [SLOT_W-1:0]   req_slot_o,
  input  logic                samp_done_i
);
  localparam int IDX_W = K_W + 1;

  seq_state_e         state_q;
  logic [IDX_W-1:0]   idx_q;
  logic               mode_q;
  logic [K_W-1:0]     k_q;
  logic [SEED_W-1:0]  seed_q;
  logic               k_ok, last;
  logic [SLOT_W-1:0]  rel;

  assign k_ok = (k_i >= K_W'(K_MIN)) && (k_i <= K_W'(K_MAX));

  noise_seq_plan #(.KW(K_W), .IW(IDX_W), .SW(SLOT_W), .EW(ETA_W)) u_plan (
    .mode_i (mode_q),
    .k_i    (k_q),
    .idx_i  (idx_q),
    .eta_o  (req_eta_o),
    .bank_o (req_bank_o),
    .rel_o  (rel),
    .last_o (last)
  );

  noise_seq_slot_map #(.KW(K_W), .SW(SLOT_W), .NB(NUM_BANKS)) u_map (
    .k_i    (k_q),
    .bank_i (req_bank_o),
    .rel_i  (rel),
    .abs_o  (req_slot_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      mode_q  <= MODE_KEYGEN;
      k_q     <= '0;
      seed_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i && k_ok) begin
          mode_q  <= mode_i;
          k_q     <= k_i;
          seed_q  <= (mode_i == MODE_ENCAPS) ? r_i : sigma_i;
          idx_q   <= '0;
          state_q <= ST_REQ;
        end
        ST_REQ: if (req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (samp_done_i) begin
          if (last) state_q <= ST_DONE;
          else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= ST_REQ;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign req_valid_o = (state_q == ST_REQ);
  assign req_seed_o  = seed_q;
  assign req_nonce_o = NONCE_W'(idx_q);
endmodule

// File: rtl/noise_seq_chk.sv
module noise_seq_chk
  import noise_seq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_o,
  input logic               done_o,
  input logic               req_valid_o,
  input logic               req_ready_i,
  input logic [SEED_W-1:0]  req_seed_o,
  input logic [NONCE_W-1:0] req_nonce_o,
  input logic [ETA_W-1:0]   req_eta_o,
  input logic               req_bank_o,
  input logic [SLOT_W-1:0]  req_slot_o,
  input logic               mode_q
);
  a_r7_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_nonce_o) &&
      $stable(req_slot_o) && $stable(req_eta_o) && $stable(req_bank_o) && $stable(req_seed_o));

  a_r7_drop_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i |=> !req_valid_o);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  a_r6_slot_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_slot_o < SLOT_W'(SLOT_COUNT));

  a_r6_t_bank_encaps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_bank_o |-> mode_q && (req_eta_o == ETA_W'(ETA_STD)));

  a_r3_keygen_se_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !mode_q |-> !req_bank_o);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o && !done_o);
endmodule

bind noise_seq_ctrl noise_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_seed_o  (req_seed_o),
  .req_nonce_o (req_nonce_o),
  .req_eta_o   (req_eta_o),
  .req_bank_o  (req_bank_o),
  .req_slot_o  (req_slot_o),
  .mode_q      (mode_q)
);

// File: tb/sim_noise_seq_ctrl.sv
`timescale 1ns/1ps
module sim_noise_seq_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, mode_s = 1'b0, ready = 1'b0, sdone = 1'b0;
  logic [2:0]   k_s = 3'd2;
  logic [255:0] sigma = {8{32'h5a3c_91e7}};
  logic [255:0] rseed = {8{32'hc0de_2468}};
  logic         busy, done, req_valid, req_bank;
  logic [255:0] req_seed;
  logic [7:0]   req_nonce;
  logic [1:0]   req_eta;
  logic [4:0]   req_slot;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  noise_seq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode_s), .k_i(k_s),
    .sigma_i(sigma), .r_i(rseed), .busy_o(busy), .done_o(done),
    .req_valid_o(req_valid), .req_ready_i(ready), .req_seed_o(req_seed),
    .req_nonce_o(req_nonce), .req_eta_o(req_eta), .req_bank_o(req_bank),
    .req_slot_o(req_slot), .samp_done_i(sdone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle_quiet(input string req, input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      check(!busy && !req_valid && !done, req, "idle outputs",
            {busy, req_valid, done}, 0);
    end
  endtask

  // One full sequence with an in-bench sampler model.
  task automatic run_seq(input bit md, input int k, input int hold,
                         input bit poke, input int stop_at);
    int n    = md ? 2*k + 1 : 2*k;
    int eta1 = (k == 2) ? 3 : 2;
    string rq = md ? "R4" : "R3";
    @(negedge clk); start = 1'b1; mode_s = md; k_s = 3'(k);
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < n; i++) begin
      int e_eta, e_bank, e_slot;
      e_eta  = (md && i >= k) ? 2 : eta1;
      e_bank = (md && i == 2*k) ? 1 : 0;
      e_slot = e_bank ? k*k + 2*k : k*k + i;
      check(req_valid && busy, "R7", "request raised", req_valid, 1);
      check(req_nonce == 8'(i), rq, "nonce", req_nonce, i);
      check(req_seed == (md ? rseed : sigma), rq, "seed low word",
            longint'(req_seed[63:0]), longint'(md ? rseed[63:0] : sigma[63:0]));
      check(req_eta == 2'(e_eta), md ? "R5" : "R3", "eta", req_eta, e_eta);
      check(req_bank == 1'(e_bank), md ? "R6" : "R3", "bank", req_bank, e_bank);
      check(req_slot == 5'(e_slot), md ? "R6" : "R3", "slot", req_slot, e_slot);
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        check(req_valid && req_nonce == 8'(i) && req_slot == 5'(e_slot), "R7",
              "held without ack", req_nonce, i);
      end
      ready = 1'b1; @(negedge clk); ready = 1'b0;
      check(!req_valid, "R7", "low after ack", req_valid, 0);
      if (poke) begin
        start = 1'b1; mode_s = ~md; k_s = 3'd4; @(negedge clk); start = 1'b0;
      end
      if (i == stop_at) return;
      @(negedge clk);
      check(!req_valid && !done, "R7", "quiet while sampling", req_valid, 0);
      sdone = 1'b1; @(negedge clk); sdone = 1'b0;
      if (i == n - 1)
        check(done && busy, "R8", "done pulse", {done, busy}, 3);
      else
        check(req_valid && !done, "R7", "next request", req_valid, 1);
    end
    @(negedge clk);
    check(!done && !busy, "R8", "done one cycle, busy drops", {done, busy}, 0);
    idle_quiet(poke ? "R2" : "R8", 3);
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !req_valid, "R1", "reset state", {busy, done, req_valid}, 0);
    rst_n = 1'b1;
    idle_quiet("R1", 2);
  endtask

  task automatic test_bad_k;
    k_s = 3'd5; mode_s = 1'b1;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    idle_quiet("R2", 3);
    k_s = 3'd1; mode_s = 1'b0;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    idle_quiet("R2", 3);
  endtask

  task automatic test_reset_midrun;
    run_seq(1'b1, 3, 0, 1'b0, 1);   // stop in sampling phase of poly 1
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !req_valid && !done, "R1", "mid-run reset idle", {busy, req_valid}, 0);
    rst_n = 1'b1;
    run_seq(1'b0, 2, 0, 1'b0, -1);  // R1: restarts from nonce 0
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    run_seq(1'b0, 2, 0, 1'b0, -1);
    run_seq(1'b1, 2, 2, 1'b0, -1);
    run_seq(1'b1, 3, 0, 1'b0, -1);
    run_seq(1'b1, 4, 1, 1'b0, -1);
    run_seq(1'b0, 4, 3, 1'b0, -1);
    run_seq(1'b0, 3, 0, 1'b1, -1);  // R2: start while busy
    run_seq(1'b1, 2, 0, 1'b1, -1);
    test_bad_k();
    test_reset_midrun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule